// File: doc/BRIEF.md
# Descriptor Ring Fetch Controller

This block steers one DMA channel around a circular ring of fixed-size descriptors. Software sets up three things: the ring's base address, its length, and a tail pointer. The block keeps a current-descriptor pointer and asks a bus master for each descriptor in turn over a request/acknowledge pair. After each acknowledged fetch, the pointer moves on by one descriptor. When it leaves the last slot, it jumps back to the base.

Ownership follows from the pointers alone. Every slot from the current pointer up to the slot before the tail belongs to the channel. When the current pointer reaches the tail, the channel goes quiet and reports itself suspended. Software hands over more descriptors by writing a tail that lies further round the ring, which restarts fetching. A software write never advances the tail by a full ring or more.

A level-sensitive run control starts and stops only this channel. Starting the channel reloads the pointer from the base. Stopping it lets a fetch that is already in flight finish first. Base address and length are held steady while the channel runs.

Top module: `ring_fetch_ctrl`

## Requirements
- R1: After reset, the channel is stopped (`stopped_o`=1), `req_o`=0 and `suspended_o`=0.
- R2: When `run_i` is seen high while the channel is stopped, `cur_addr_o` equals `base_addr_i` one cycle later, and `stopped_o` is 0.
- R3: Once `req_o` is raised, it stays high with an unchanged `req_addr_o` until a cycle with `ack_i`=1.
- R4: A fetch acknowledged at address A that is not the last slot moves `cur_addr_o` to A+16 on the next cycle. Descriptors are 16 bytes.
- R5: `ring_len_i` holds the slot count minus one, so the last slot is at base + 16·`ring_len_i`. A fetch acknowledged there returns `cur_addr_o` to `base_addr_i`.
- R6: While the channel runs and the current pointer equals the tail, `suspended_o` is 1 and `req_o` is 0. No descriptor at or beyond the tail is fetched.
- R7: A `tail_wr_i` pulse that moves the tail ahead of the current pointer makes `req_o` rise two cycles after the write cycle.
- R8: A tail write that lands while a fetch is in flight causes no extra fetch and no skipped fetch. The fetched addresses are exactly the consecutive slots from the start point up to the slot before the final tail.
- R9: If `run_i` falls while `req_o` is high, `req_o` stays high until the acknowledge. The cycle after the acknowledge, `stopped_o` is 1 and the pointer has advanced.
- R10: If `run_i` falls while the channel is suspended, `stopped_o` is 1 one cycle later.
- R11: `req_addr_o` and `cur_addr_o` both carry the current-descriptor pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Channel run (1) / stop (0) control |
| base_addr_i | input | ADDR_W | Ring base address, 16-byte aligned |
| ring_len_i | input | LEN_W | Number of ring slots minus one |
| tail_wr_i | input | 1 | Tail pointer write strobe |
| tail_addr_i | input | ADDR_W | New tail pointer value |
| req_o | output | 1 | Descriptor fetch request |
| req_addr_o | output | ADDR_W | Address of the requested descriptor |
| ack_i | input | 1 | Fetch completion acknowledge |
| cur_addr_o | output | ADDR_W | Current descriptor pointer |
| suspended_o | output | 1 | Running, but pointer has caught up with the tail |
| stopped_o | output | 1 | Channel is stopped |

## Verification
The hardest situation to reach is a tail write that lands in the same cycle as an acknowledge, or just before the suspend comparison, with the ring wrapping at the same time. Only that combination can expose an extra or a missing fetch.

The stimulus produces it by running long random stretches on small rings. It mixes random acknowledge delays with frequent tail writes, and each write advances the tail by a random amount that always leaves less than a full ring outstanding. A bench-side slot model checks every acknowledged address and rejects any fetch made while the model says nothing is owned.

Directed steps cover the other cases: a stop that arrives during a pending handshake, a stop while suspended, and a restart from the base.

// File: rtl/rfc_pkg.sv
package rfc_pkg;
   typedef enum logic [1:0] {
      ST_HALT = 2'd0,
      ST_EVAL = 2'd1,
      ST_WAIT = 2'd2
   } walk_state_e;
endpackage

// File: rtl/rfc_tail_reg.sv
module rfc_tail_reg #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wdata_i,
   output logic [ADDR_W-1:0] tail_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    tail_o <= '0;
      else if (wr_i) tail_o <= wdata_i;
   end
endmodule

// File: rtl/rfc_slot_step.sv
module rfc_slot_step #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int DESC_BYTES = 16
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] cur_i,
   output logic [ADDR_W-1:0] last_o,
   output logic              at_last_o,
   output logic [ADDR_W-1:0] next_o
);
   localparam int SHIFT = $clog2(DESC_BYTES);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   initial begin
      assert (DESC_BYTES >= 1 && (1 << SHIFT) == DESC_BYTES && LEN_W + SHIFT <= ADDR_W)
         else $error("rfc_slot_step: descriptor size must be a power of two that fits the address");
   end

   generate
      if (SHIFT == 0) begin : g_unit
         assign last_o = base_i + ADDR_W'(len_i);
      end else begin : g_shift
         assign last_o = base_i + (ADDR_W'(len_i) << SHIFT);
      end
   endgenerate

   assign at_last_o = (cur_i == last_o);
   assign next_o    = at_last_o ? base_i : cur_i + STEP;
endmodule

// File: rtl/rfc_walker.sv
module rfc_walker
   import rfc_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              ack_i,
   input  logic              caught_up_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] next_i,
   output walk_state_e       state_o,
   output logic [ADDR_W-1:0] cur_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_o <= ST_HALT;
         cur_o   <= '0;
      end else begin
         unique case (state_o)
            ST_HALT: if (run_i) begin
               cur_o   <= base_i;
               state_o <= ST_EVAL;
            end
            ST_EVAL: begin
               if (!run_i)            state_o <= ST_HALT;
               else if (!caught_up_i) state_o <= ST_WAIT;
            end
            ST_WAIT: if (ack_i) begin
               cur_o   <= next_i;
               state_o <= run_i ? ST_EVAL : ST_HALT;
            end
            default: state_o <= ST_HALT;
         endcase
      end
   end

   // R3: an open handshake keeps its state and address until acknowledged
   assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_WAIT && !ack_i) |=> (state_o == ST_WAIT && $stable(cur_o)));

   // R6: the pointer never moves while the walker is deciding or suspended
   assert_eval_no_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_EVAL) |=> $stable(cur_o));
endmodule

// File: rtl/ring_fetch_ctrl.sv
module ring_fetch_ctrl
   import rfc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int DESC_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic [ADDR_W-1:0] base_addr_i,
   input  logic [LEN_W-1:0]  ring_len_i,
   input  logic              tail_wr_i,
   input  logic [ADDR_W-1:0] tail_addr_i,
   output logic              req_o,
   output logic [ADDR_W-1:0] req_addr_o,
   input  logic              ack_i,
   output logic [ADDR_W-1:0] cur_addr_o,
   output logic              suspended_o,
   output logic              stopped_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

   walk_state_e       state;
   logic [ADDR_W-1:0] cur, tail, last_slot, next_slot;
   logic              at_last, caught_up;

   rfc_tail_reg #(.ADDR_W(ADDR_W)) u_tail (
      .clk(clk), .rst_n(rst_n), .wr_i(tail_wr_i), .wdata_i(tail_addr_i), .tail_o(tail));

   rfc_slot_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DESC_BYTES(DESC_BYTES)) u_step (
      .base_i(base_addr_i), .len_i(ring_len_i), .cur_i(cur),
      .last_o(last_slot), .at_last_o(at_last), .next_o(next_slot));

   assign caught_up = (cur == tail);

   rfc_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n), .run_i(run_i), .ack_i(ack_i), .caught_up_i(caught_up),
      .base_i(base_addr_i), .next_i(next_slot), .state_o(state), .cur_o(cur));

   assign req_o       = (state == ST_WAIT);
   assign req_addr_o  = cur;
   assign cur_addr_o  = cur;
   assign stopped_o   = (state == ST_HALT);
   assign suspended_o = (state == ST_EVAL) && caught_up;

   // R4: ordinary advance by one descriptor
   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && !at_last) |=> (cur_addr_o == $past(cur_addr_o) + STEP));

   // R5: leaving the last slot returns to the base
   assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && ack_i && at_last) |=> (cur_addr_o == $past(base_addr_i)));

   // R5: a running pointer stays inside the ring
   assert_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stopped_o) |-> (cur_addr_o >= base_addr_i && cur_addr_o <= last_slot));

   // R9: a stop never drops a pending request
   assert_stop_drains_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_o && !ack_i && !run_i) |=> req_o);

   // R10: a stop while suspended halts on the next cycle
   assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (suspended_o && !run_i) |=> stopped_o);
endmodule

// File: tb/test_ring_fetch_ctrl.sv
module test_ring_fetch_ctrl;
   localparam int AW = 32;
   localparam int LW = 8;

   logic clk = 0, rst_n = 0, run = 0, tail_wr = 0, ack = 0;
   logic [AW-1:0] base = '0, tail_addr = '0;
   logic [LW-1:0] len = '0;
   logic req_o, suspended_o, stopped_o;
   logic [AW-1:0] req_addr_o, cur_addr_o;

   int unsigned n_chk = 0, n_bad = 0;
   int unsigned nslots, exp_slot, tail_slot, wait_cnt, fetches;
   bit done = 0;

   always #4 clk = ~clk;

   ring_fetch_ctrl #(.ADDR_W(AW), .LEN_W(LW), .DESC_BYTES(16)) i_ring_fetch_ctrl (
      .clk(clk), .rst_n(rst_n), .run_i(run), .base_addr_i(base), .ring_len_i(len),
      .tail_wr_i(tail_wr), .tail_addr_i(tail_addr), .req_o(req_o), .req_addr_o(req_addr_o),
      .ack_i(ack), .cur_addr_o(cur_addr_o), .suspended_o(suspended_o), .stopped_o(stopped_o));

   function automatic logic [AW-1:0] slot_addr(int unsigned s);
      return base + AW'(s * 16);
   endfunction

   task automatic chk(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic write_tail(int unsigned s);
      @(negedge clk);
      tail_slot = s; tail_addr = slot_addr(s); tail_wr = 1;
      @(negedge clk);
      tail_wr = 0;
   endtask

   task automatic do_cycle(bit allow_tail);
      int unsigned outst, room, k;
      @(negedge clk);
      ack = 0; tail_wr = 0;
      if (suspended_o && req_o) chk(0, "R6 req while suspended", 1, 0);
      if (req_o) begin
         if (wait_cnt == 0) begin
            chk(req_addr_o == slot_addr(exp_slot), "R4/R5 fetch address", req_addr_o, slot_addr(exp_slot));
            chk(cur_addr_o == req_addr_o, "R11 pointer outputs", cur_addr_o, req_addr_o);
            if (exp_slot == tail_slot) chk(0, "R8 fetch beyond tail", req_addr_o, slot_addr(tail_slot));
            exp_slot = (exp_slot + 1) % nslots;
            ack = 1; fetches++;
            wait_cnt = $urandom % 4;
         end else wait_cnt--;
      end
      if (allow_tail && ($urandom % 5) == 0) begin
         outst = (tail_slot + nslots - exp_slot) % nslots;
         room  = nslots - 1 - outst;
         if (room > 0) begin
            k = 1 + ($urandom % room);
            tail_slot = (tail_slot + k) % nslots;
            tail_addr = slot_addr(tail_slot);
            tail_wr = 1;
         end
      end
   endtask

   task automatic random_phase(int unsigned cycles);
      for (int i = 0; i < cycles; i++) do_cycle(1);
      for (int i = 0; i < 60; i++) do_cycle(0);
      @(negedge clk);
      ack = 0;
      chk(suspended_o == 1, "R6 suspended after drain", AW'(suspended_o), 1);
      chk(cur_addr_o == slot_addr(tail_slot), "R8 pointer at tail", cur_addr_o, slot_addr(tail_slot));
      chk(req_o == 0, "R6 quiet after drain", AW'(req_o), 0);
   endtask

   task automatic start_at_base();
      write_tail(0);
      exp_slot = 0; wait_cnt = 0;
      run = 1;
      @(negedge clk);
      chk(cur_addr_o == base, "R2 pointer loaded", cur_addr_o, base);
      chk(stopped_o == 0, "R2 running", AW'(stopped_o), 0);
   endtask

   initial begin
      #(8 * 150000);
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      fetches = 0;
      base = 32'h0000_1040; len = 8'd5; nslots = 6;
      repeat (3) @(negedge clk);
      chk(stopped_o == 1 && req_o == 0 && suspended_o == 0, "R1 reset state",
          {29'd0, stopped_o, req_o, suspended_o}, 32'd4);
      rst_n = 1;

      // R2/R6: start with tail at base, expect suspension, no fetch
      start_at_base();
      @(negedge clk);
      chk(suspended_o == 1 && req_o == 0, "R6 suspended at start", AW'(suspended_o), 1);

      // R7: tail write of two slots, request appears two cycles after the write cycle
      @(negedge clk);
      tail_slot = 2; tail_addr = slot_addr(2); tail_wr = 1;
      @(negedge clk); tail_wr = 0;
      chk(req_o == 0, "R7 not yet requesting", AW'(req_o), 0);
      @(negedge clk);
      chk(req_o == 1 && req_addr_o == base, "R7 resumed request", req_addr_o, base);

      // R9: stop while the handshake is open
      run = 0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(req_o == 1 && req_addr_o == base, "R9 request held during stop", req_addr_o, base);
      end
      ack = 1;
      @(negedge clk);
      ack = 0;
      chk(stopped_o == 1, "R9 stopped after ack", AW'(stopped_o), 1);
      chk(cur_addr_o == slot_addr(1), "R9 pointer advanced", cur_addr_o, slot_addr(1));

      // R2 restart from base, then R10 stop while suspended
      start_at_base();
      @(negedge clk);
      chk(suspended_o == 1, "R6 suspended after restart", AW'(suspended_o), 1);
      run = 0;
      @(negedge clk);
      chk(stopped_o == 1, "R10 stop while suspended", AW'(stopped_o), 1);

      // Random phase, six-slot ring
      start_at_base();
      random_phase(1500);

      // Random phase, three-slot ring at a new base
      @(negedge clk); run = 0;
      @(negedge clk);
      base = 32'h0002_0000; len = 8'd2; nslots = 3;
      start_at_base();
      random_phase(1500);

      chk(fetches > 100, "R8 traffic volume", AW'(fetches), 100);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule